// File: doc/BRIEF.md
# General-Purpose I/O Bank with Per-Pin Event Detection

This block is one bank of general-purpose pins, 32 by default, controlled through a small word-addressed register port. The port has an address, write data, a write strobe and a read-data output. For each pin the bank stores a direction bit and an output level. It gives software atomic mask-based set and clear operations on the output levels and on the per-pin interrupt enables. This lets a driver change some pins without a read-modify-write sequence.

Pin inputs cross into the clock domain through a synchronizer chain, and the synchronized levels can be read back. Every pin has four independent detect enables: rising edge, falling edge, low level and high level. Any combination of the four may be on. A detected condition on a pin whose interrupt enable is set latches a bit in a pending register. Software clears pending bits by writing ones. All pending bits that are also enabled are merged into a single interrupt request. A change to any detect enable reaches the detector only after a fixed settling delay.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the direction register reads all ones, so every pin is an input. Output data, interrupt enables, the four detect enables and the pending register all read zero, and `irq` is low.
- R2: Direction register (offset 0): bit n = 1 makes pin n an input and bit n = 0 makes it an output. `pin_dir` shows the register at all times.
- R3: Output data (offset 1) can be written directly. A mask written to offset 2 drives 1 on the masked bits of `pin_out`. A mask written to offset 3 drives 0 on them. Zero mask bits leave their pins unchanged.
- R4: The data-in register (offset 4) returns each pin's level after a two-flop synchronizer. A level applied before clock edge a is readable after edge a+1 and not after edge a only.
- R5: A rising-edge enable (offset 8) or falling-edge enable (offset 9) on pin n sets pending bit n two edges after the input transition. With both enabled, either transition sets it. A transition with no matching enable sets nothing.
- R6: A low-level enable (offset 10) or high-level enable (offset 11) sets pending bit n on every cycle in which the level holds. A level event in the same cycle as a write-1-to-clear of that bit leaves the bit set.
- R7: The pending register reads at offset 12. Writing a mask there clears exactly the masked bits that have no new event in that cycle, and every other bit keeps its value.
- R8: The interrupt enable reads at offset 5. Ones written to offset 6 set enables and ones written to offset 7 clear them. A pending bit is set only while its pin's interrupt enable is 1.
- R9: `irq` is high exactly when some pending bit has its interrupt enable set. Clearing the enable masks `irq` but keeps the pending bit.
- R10: A detect-enable write sampled at clock edge k first takes effect at edge k+5 (SETTLE_CYC). A condition already present sets the pending bit at edge k+5 and not at edge k+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register word address |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | NPINS | Write data or mask |
| rd_data | output | NPINS | Read data for `addr`, combinational |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output level per pin |
| pin_dir | output | NPINS | Direction per pin, 1 = input |
| irq | output | 1 | Merged interrupt request |

## Verification
A software write-1-to-clear to the pending register and a fresh detection on the same bit can land in one clock cycle. The bench provokes this by holding a high level on one pin while it clears that bit, a stale edge-detected bit and a low-level bit in a single write. It then judges that only the stale edge bit drops while both level bits stay set. A second pairing is an interrupt-enable clear while a bit is pending: `irq` must fall while the pending bit stays readable, and `irq` must return when the enable is set again.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int unsigned REG_ADDR_W = 4;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_DIR      = 4'd0,
      REG_DOUT     = 4'd1,
      REG_DOUT_SET = 4'd2,
      REG_DOUT_CLR = 4'd3,
      REG_DIN      = 4'd4,
      REG_IEN      = 4'd5,
      REG_IEN_SET  = 4'd6,
      REG_IEN_CLR  = 4'd7,
      REG_RISE     = 4'd8,
      REG_FALL     = 4'd9,
      REG_LOW      = 4'd10,
      REG_HIGH     = 4'd11,
      REG_PEND     = 4'd12
   } gpio_reg_e;

   localparam int unsigned DET_KINDS = 4;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] q_prev
);
   localparam int unsigned LAST = STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [LAST+1];

   for (genvar i = 0; i <= LAST; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q      = chain[LAST-1];
   assign q_prev = chain[LAST];

endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
   import gpio_bank_pkg::*;
#(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned SETTLE = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cur,
   input  logic [WIDTH-1:0] prev,
   input  logic [WIDTH-1:0] rise_en,
   input  logic [WIDTH-1:0] fall_en,
   input  logic [WIDTH-1:0] low_en,
   input  logic [WIDTH-1:0] high_en,
   output logic [WIDTH-1:0] evt
);
   localparam int unsigned DEPTH = SETTLE - 1;
   localparam int unsigned CFG_W = DET_KINDS * WIDTH;

   if (SETTLE < 2) begin : g_bad_settle
      $error("gpio_detect: SETTLE must be at least 2");
   end

   logic [CFG_W-1:0] cfg_in;
   logic [CFG_W-1:0] cfg_eff;
   logic [CFG_W-1:0] pipe [DEPTH];

   assign cfg_in = {high_en, low_en, fall_en, rise_en};

   for (genvar s = 0; s < DEPTH; s++) begin : g_pipe
      if (s == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= cfg_in;
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[s] <= '0;
            else        pipe[s] <= pipe[s-1];
         end
      end
   end

   assign cfg_eff = pipe[DEPTH-1];

   logic [WIDTH-1:0] rise_eff, fall_eff, low_eff, high_eff;
   assign rise_eff = cfg_eff[0*WIDTH +: WIDTH];
   assign fall_eff = cfg_eff[1*WIDTH +: WIDTH];
   assign low_eff  = cfg_eff[2*WIDTH +: WIDTH];
   assign high_eff = cfg_eff[3*WIDTH +: WIDTH];

   always_comb begin
      evt = (rise_eff &  cur & ~prev)
          | (fall_eff & ~cur &  prev)
          | (low_eff  & ~cur)
          | (high_eff &  cur);
   end

endmodule

// File: rtl/gpio_pending.sv
module gpio_pending #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] evt,
   input  logic [WIDTH-1:0] ien,
   input  logic [WIDTH-1:0] clr,
   output logic [WIDTH-1:0] pend,
   output logic             irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~clr) | (evt & ien);
   end

   assign irq = |(pend & ien);

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NPINS       = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SETTLE_CYC  = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [REG_ADDR_W-1:0] addr,
   input  logic                  wr_en,
   input  logic [NPINS-1:0]      wr_data,
   output logic [NPINS-1:0]      rd_data,
   input  logic [NPINS-1:0]      pin_in,
   output logic [NPINS-1:0]      pin_out,
   output logic [NPINS-1:0]      pin_dir,
   output logic                  irq
);
   if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
      $error("gpio_irq_bank: NPINS must lie in 1..32");
   end

   logic [NPINS-1:0] dir_q, dout_q, ien_q;
   logic [NPINS-1:0] rise_q, fall_q, low_q, high_q;
   logic [NPINS-1:0] din_s, din_prev, evt, status_q, pend_clr;

   function automatic logic hit(input logic [REG_ADDR_W-1:0] a, input gpio_reg_e r);
      return a == r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '1;
         dout_q <= '0;
         ien_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
         low_q  <= '0;
         high_q <= '0;
      end else if (wr_en) begin
         if (hit(addr, REG_DIR))      dir_q  <= wr_data;
         if (hit(addr, REG_DOUT))     dout_q <= wr_data;
         if (hit(addr, REG_DOUT_SET)) dout_q <= dout_q | wr_data;
         if (hit(addr, REG_DOUT_CLR)) dout_q <= dout_q & ~wr_data;
         if (hit(addr, REG_IEN_SET))  ien_q  <= ien_q | wr_data;
         if (hit(addr, REG_IEN_CLR))  ien_q  <= ien_q & ~wr_data;
         if (hit(addr, REG_RISE))     rise_q <= wr_data;
         if (hit(addr, REG_FALL))     fall_q <= wr_data;
         if (hit(addr, REG_LOW))      low_q  <= wr_data;
         if (hit(addr, REG_HIGH))     high_q <= wr_data;
      end
   end

   assign pend_clr = (wr_en && hit(addr, REG_PEND)) ? wr_data : '0;

   gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d      (pin_in),
      .q      (din_s),
      .q_prev (din_prev)
   );

   gpio_detect #(.WIDTH(NPINS), .SETTLE(SETTLE_CYC)) u_detect (
      .clk     (clk),
      .rst_n   (rst_n),
      .cur     (din_s),
      .prev    (din_prev),
      .rise_en (rise_q),
      .fall_en (fall_q),
      .low_en  (low_q),
      .high_en (high_q),
      .evt     (evt)
   );

   gpio_pending #(.WIDTH(NPINS)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt),
      .ien   (ien_q),
      .clr   (pend_clr),
      .pend  (status_q),
      .irq   (irq)
   );

   always_comb begin
      rd_data = '0;
      case (addr)
         REG_DIR:  rd_data = dir_q;
         REG_DOUT: rd_data = dout_q;
         REG_DIN:  rd_data = din_s;
         REG_IEN:  rd_data = ien_q;
         REG_RISE: rd_data = rise_q;
         REG_FALL: rd_data = fall_q;
         REG_LOW:  rd_data = low_q;
         REG_HIGH: rd_data = high_q;
         REG_PEND: rd_data = status_q;
         default:  rd_data = '0;
      endcase
   end

   assign pin_out = dout_q;
   assign pin_dir = dir_q;

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [REG_ADDR_W-1:0] addr,
   input logic                  wr_en,
   input logic [WIDTH-1:0]      wr_data,
   input logic [WIDTH-1:0]      dout,
   input logic [WIDTH-1:0]      ien,
   input logic [WIDTH-1:0]      evt,
   input logic [WIDTH-1:0]      status,
   input logic                  irq
);
   a_r3_set_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_DOUT_SET) |=> ((dout & $past(wr_data)) == $past(wr_data)));

   a_r3_clr_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_DOUT_CLR) |=> ((dout & $past(wr_data)) == '0));

   a_r3_set_keeps_rest: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_DOUT_SET) |=>
         ((dout & ~$past(wr_data)) == ($past(dout) & ~$past(wr_data))));

   a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == REG_PEND) |=> ((status & $past(wr_data) & ~$past(evt)) == '0));

   a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((status & ~$past(status) & ~$past(ien)) == '0));

   a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (status == '0) |-> !irq);

   a_r9_masked_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (ien == '0) |-> !irq);

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.WIDTH(NPINS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .addr    (addr),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .dout    (dout_q),
   .ien     (ien_q),
   .evt     (evt),
   .status  (status_q),
   .irq     (irq)
);

// File: tb/tb_gpio_irq_bank.sv
module tb_gpio_irq_bank;
   import gpio_bank_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out;
   logic [31:0] pin_dir;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_irq_bank #(.NPINS(32), .SYNC_STAGES(2), .SETTLE_CYC(5)) dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_dir(pin_dir), .irq(irq)
   );

   task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %08h expected %08h", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic drive(input logic [31:0] v);
      @(negedge clk);
      pin_in = v;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(REG_DIR, v);  chk("R1", "dir reset", v, 32'hFFFF_FFFF);
      chk("R1", "pin_dir reset", pin_dir, 32'hFFFF_FFFF);
      rd(REG_DOUT, v); chk("R1", "dout reset", v, 0);
      rd(REG_IEN, v);  chk("R1", "ien reset", v, 0);
      rd(REG_RISE, v); chk("R1", "rise reset", v, 0);
      rd(REG_HIGH, v); chk("R1", "high reset", v, 0);
      rd(REG_PEND, v); chk("R1", "pending reset", v, 0);
      chk("R1", "irq reset", {31'b0, irq}, 0);
   endtask

   task automatic t_dir;
      logic [31:0] v;
      wr(REG_DIR, 32'h0000_FFFF);
      rd(REG_DIR, v); chk("R2", "dir readback", v, 32'h0000_FFFF);
      chk("R2", "pin_dir", pin_dir, 32'h0000_FFFF);
   endtask

   task automatic t_dout;
      logic [31:0] v;
      wr(REG_DOUT, 32'h00F0_F0F0);
      chk("R3", "direct write", pin_out, 32'h00F0_F0F0);
      wr(REG_DOUT_SET, 32'h0F00_0001);
      chk("R3", "set mask", pin_out, 32'h0FF0_F0F1);
      wr(REG_DOUT_CLR, 32'h0000_00F1);
      rd(REG_DOUT, v); chk("R3", "clear mask", v, 32'h0FF0_F000);
      chk("R3", "clear pins", pin_out, 32'h0FF0_F000);
   endtask

   task automatic t_din;
      logic [31:0] v;
      drive(32'hA5A5_0F0F);
      cyc(1); rd(REG_DIN, v); chk("R4", "din after one edge", v, 0);
      cyc(1); rd(REG_DIN, v); chk("R4", "din after two edges", v, 32'hA5A5_0F0F);
      drive(32'h0000_0002);
      cyc(3); rd(REG_DIN, v); chk("R4", "din second pattern", v, 32'h0000_0002);
   endtask

   task automatic t_edges;
      logic [31:0] v;
      wr(REG_IEN_SET, 32'h7);
      wr(REG_RISE, 32'h5);
      wr(REG_FALL, 32'h6);
      cyc(7); rd(REG_PEND, v); chk("R5", "no event while steady", v, 0);
      drive(32'h3); cyc(3); rd(REG_PEND, v); chk("R5", "rise bit0", v, 32'h1);
      chk("R9", "irq on pending", {31'b0, irq}, 1);
      wr(REG_PEND, 32'h1); rd(REG_PEND, v); chk("R7", "w1c bit0", v, 0);
      chk("R9", "irq after clear", {31'b0, irq}, 0);
      drive(32'h1); cyc(3); rd(REG_PEND, v); chk("R5", "fall bit1", v, 32'h2);
      wr(REG_PEND, 32'h2);
      drive(32'h5); cyc(3); rd(REG_PEND, v); chk("R5", "both edges rise bit2", v, 32'h4);
      wr(REG_PEND, 32'h4);
      drive(32'h1); cyc(3); rd(REG_PEND, v); chk("R5", "both edges fall bit2", v, 32'h4);
      wr(REG_PEND, 32'h4);
      drive(32'h0); cyc(3); rd(REG_PEND, v); chk("R5", "fall ignored on rise-only bit0", v, 0);
      wr(REG_RISE, 0); wr(REG_FALL, 0); wr(REG_IEN_CLR, 32'h7);
      cyc(6);
   endtask

   task automatic t_levels;
      logic [31:0] v;
      wr(REG_IEN_SET, 32'h31);
      wr(REG_RISE, 32'h01);
      wr(REG_HIGH, 32'h10);
      wr(REG_LOW, 32'h20);
      cyc(7); rd(REG_PEND, v); chk("R6", "low level bit5", v, 32'h20);
      drive(32'h11); cyc(3); rd(REG_PEND, v); chk("R6", "high level bit4 plus rise bit0", v, 32'h31);
      wr(REG_PEND, 32'h31);
      rd(REG_PEND, v); chk("R6", "levels win over same-cycle clear", v, 32'h30);
      drive(32'h31); cyc(3);
      wr(REG_PEND, 32'h20);
      rd(REG_PEND, v); chk("R7", "clear after low level ends", v, 32'h10);
      wr(REG_HIGH, 0); wr(REG_LOW, 0); wr(REG_RISE, 0);
      cyc(6);
      wr(REG_PEND, 32'hFFFF_FFFF);
      rd(REG_PEND, v); chk("R7", "all cleared", v, 0);
      wr(REG_IEN_CLR, 32'h31);
   endtask

   task automatic t_gate;
      logic [31:0] v;
      wr(REG_RISE, 32'h40);
      cyc(6);
      drive(32'h71); cyc(3); rd(REG_PEND, v); chk("R8", "no latch without enable", v, 0);
      chk("R8", "irq low without enable", {31'b0, irq}, 0);
      wr(REG_IEN_SET, 32'h40);
      rd(REG_IEN, v); chk("R8", "ien set readback", v, 32'h40);
      drive(32'h31); cyc(3);
      drive(32'h71); cyc(3); rd(REG_PEND, v); chk("R8", "latch with enable", v, 32'h40);
      chk("R9", "irq high", {31'b0, irq}, 1);
      wr(REG_IEN_CLR, 32'h40);
      rd(REG_IEN, v); chk("R8", "ien clear readback", v, 0);
      chk("R9", "irq masked", {31'b0, irq}, 0);
      rd(REG_PEND, v); chk("R9", "pending kept while masked", v, 32'h40);
      wr(REG_IEN_SET, 32'h40);
      chk("R9", "irq back on re-enable", {31'b0, irq}, 1);
      wr(REG_PEND, 32'h40);
      chk("R9", "irq low after clear", {31'b0, irq}, 0);
      wr(REG_RISE, 0);
   endtask

   task automatic t_settle;
      logic [31:0] v;
      drive(32'h171); cyc(3);
      wr(REG_IEN_SET, 32'h100);
      wr(REG_HIGH, 32'h100);
      cyc(4); rd(REG_PEND, v); chk("R10", "not yet at edge k+4", v & 32'h100, 0);
      cyc(1); rd(REG_PEND, v); chk("R10", "active at edge k+5", v & 32'h100, 32'h100);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_dir();
      t_dout();
      t_din();
      t_edges();
      t_levels();
      t_gate();
      t_settle();
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

endmodule